// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel Sequencer

This block sequences one DMA channel through a chain of transfer descriptors kept in memory. Software writes the address of the first descriptor into the current-descriptor register and then sets the start bit in the mode register. The channel reads the four-word descriptor and checks it. It copies the requested number of bytes one 32-bit word at a time, reading from the source and then writing to the destination. After that it follows the link word to the next descriptor. The descriptor whose link word carries the end flag is the last one. When it completes, the channel goes idle and records an end-of-list event.

Software can hold a launch until an external pin is asserted. It can abort a running transfer, or halt it by clearing both the start bit and the external-start enable. The status register shows whether the channel is busy or halted. It also holds sticky event bits, each cleared by writing one to it. A single interrupt line reports the end-of-list event and the error events, each group gated by its own enable bit. All memory traffic uses a single request/acknowledge port. The requester holds a request and its address until the memory acknowledges it, and an error flag returned with the acknowledge marks a failed access.

Top module: `dchain_seq`

## Requirements
- R1: After reset the mode register, status register, current-descriptor register and count register read 0, and `irq` and `mem_req` are 0.
- R2: Writing the mode register (select 0) with the start bit (bit 0) going from 0 to 1 while the channel is idle makes the channel busy (status bit 4) from the next cycle. The descriptor at the current address D is read as source at D+0, destination at D+4, link at D+8 and byte count at D+12.
- R3: For each descriptor the channel reads word k from source+4k and writes it to destination+4k, for k ascending from 0 to count/4-1, and it issues no other writes.
- R4: When a descriptor's link word has bit 0 clear, the channel continues with the descriptor at that link address. While the channel is busy, and after it finishes, the current-descriptor register (select 2) holds the address of the descriptor being processed or last processed.
- R5: When the channel finishes a descriptor it sets descriptor-done (status bit 0). When that descriptor's link bit 0 is set, the channel also sets end-of-list (status bit 1) and goes idle with halted (status bit 5) clear.
- R6: Writing the start bit as 1 while it is already 1 does not launch the channel. The start bit has to be written 0 first.
- R7: When external-start enable (mode bit 2) is set at launch, the channel is busy but issues no memory request until the `ext_start` input is high.
- R8: Writing the abort bit (mode bit 1) while the channel is busy stops it after the memory access in flight completes. Busy then clears, halted sets, and no further requests are issued.
- R9: Writing the mode register with both the start bit and external-start enable clear while the channel is busy stops it in the same way: busy clears and halted sets.
- R10: A current address with any of its low 5 bits set at launch, or a link address with any of bits 4 to 1 set, sets programming error (status bit 3) and halted. No data is written.
- R11: A byte count of 0 is a null transfer. It sets programming error and halted, and the count register (select 3) then reads 0. A count above MAX_BYTES, or one that is not a multiple of 4, also sets programming error and halted, and no data is moved.
- R12: A memory access acknowledged with `mem_err` high sets transfer error (status bit 2) and halted, and the channel issues no further requests.
- R13: Writing the status register (select 1) clears each event bit (bits 3..0) whose write-data bit is 1 and leaves the other event bits unchanged. Writing 0 changes nothing.
- R14: `irq` is high one cycle after end-of-list is set while its enable (mode bit 3) is set, or after an error bit is set while its enable (mode bit 4) is set. `irq` falls one cycle after the causing bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 mode, 1 status, 2 current descriptor, 3 count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| ext_start | input | 1 | External start pin |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed, valid with mem_ack |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions are checked on every cycle. They cover these behaviours:
- A pending request keeps its address until it is acknowledged.
- Data moves only with an aligned descriptor and a legal remaining count.
- The channel is idle whenever it is halted, and a normal end of list leaves it un-halted.
- The interrupt stays low when both enables are clear.

The scenarios in the bench show the remaining behaviours:
- The exact order of copied words across a two-descriptor chain, matched against a scoreboard.
- The current-descriptor register advancing along the chain.
- The wait for the external pin.
- Where abort, halt, a transfer error and each programming-error case stop the transfer.
- The write-one-to-clear behaviour of the status bits.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_PIN, S_ALIGN, S_FETCH, S_CHECK, S_READ, S_WRITE
  } seq_state_t;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DESC = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;

  localparam int MB_START = 0;
  localparam int MB_ABORT = 1;
  localparam int MB_EXT   = 2;
  localparam int MB_EIE   = 3;
  localparam int MB_RIE   = 4;

  localparam int SB_DONE = 0;
  localparam int SB_END  = 1;
  localparam int SB_XERR = 2;
  localparam int SB_PERR = 3;
endpackage

// File: rtl/dchain_cnt_chk.sv
module dchain_cnt_chk #(
  parameter int MAX_BYTES = 1024
) (
  input  logic [31:0] cnt_word,
  output logic        is_zero,
  output logic        is_bad
);
  localparam logic [31:0] MAXW = 32'(MAX_BYTES);

  always_comb begin
    is_zero = (cnt_word == 32'd0);
    is_bad  = (cnt_word > MAXW) || (cnt_word[1:0] != 2'b00);
  end
endmodule

// File: rtl/dchain_irq.sv
module dchain_irq (
  input  logic clk,
  input  logic rst,
  input  logic ev_end,
  input  logic ev_err,
  input  logic en_end,
  input  logic en_err,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (ev_end & en_end) | (ev_err & en_err);
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!en_end && !en_err) |=> !irq_o); // R14
endmodule

// File: rtl/dchain_seq.sv
module dchain_seq
  import dchain_pkg::*;
#(
  parameter int AW        = 16,
  parameter int MAX_BYTES = 1024,
  parameter int ALIGN_LG  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ext_start,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          irq
);
  localparam int CW = $clog2(MAX_BYTES + 1);

  seq_state_t    state;
  logic          m_start, m_ext, m_eie, m_rie, abort_pend;
  logic [AW-1:0] cur, src, dst, nxt;
  logic [31:0]   cnt_raw, dbuf;
  logic [CW-1:0] rem;
  logic [1:0]    widx;
  logic          ev_done, ev_end, ev_xerr, ev_perr, halted;
  logic          busy, stop_now, launch, cnt_zero, cnt_bad, last_beat;
  logic          unused_bits;

  assign unused_bits = ^{reg_wdata, mem_rdata};

  assign busy      = (state != S_IDLE);
  assign stop_now  = abort_pend || (!m_start && !m_ext);
  assign launch    = reg_wr && (reg_sel == SEL_MODE) && reg_wdata[MB_START] && !m_start && !busy;
  assign last_beat = (rem == CW'(4));

  dchain_cnt_chk #(.MAX_BYTES(MAX_BYTES)) u_cnt_chk (
    .cnt_word(cnt_raw), .is_zero(cnt_zero), .is_bad(cnt_bad));

  dchain_irq u_irq (
    .clk(clk), .rst(rst), .ev_end(ev_end), .ev_err(ev_xerr | ev_perr),
    .en_end(m_eie), .en_err(m_rie), .irq_o(irq));

  always_comb begin
    mem_req   = (state == S_FETCH) || (state == S_READ) || (state == S_WRITE);
    mem_we    = (state == S_WRITE);
    mem_wdata = dbuf;
    case (state)
      S_READ:  mem_addr = src;
      S_WRITE: mem_addr = dst;
      default: mem_addr = cur + {{(AW-4){1'b0}}, widx, 2'b00};
    endcase
  end

  always_comb begin
    case (reg_sel)
      SEL_MODE: reg_rdata = {27'd0, m_rie, m_eie, m_ext, 1'b0, m_start};
      SEL_STAT: reg_rdata = {26'd0, halted, busy, ev_perr, ev_xerr, ev_end, ev_done};
      SEL_DESC: reg_rdata = {{(32-AW){1'b0}}, cur};
      default:  reg_rdata = {{(32-CW){1'b0}}, rem};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      {m_start, m_ext, m_eie, m_rie, abort_pend} <= '0;
      {ev_done, ev_end, ev_xerr, ev_perr, halted} <= '0;
      cur <= '0; src <= '0; dst <= '0; nxt <= '0;
      cnt_raw <= '0; dbuf <= '0; rem <= '0; widx <= '0;
    end else begin
      if (reg_wr && reg_sel == SEL_MODE) begin
        m_start <= reg_wdata[MB_START];
        m_ext   <= reg_wdata[MB_EXT];
        m_eie   <= reg_wdata[MB_EIE];
        m_rie   <= reg_wdata[MB_RIE];
        if (reg_wdata[MB_ABORT] && busy) abort_pend <= 1'b1;
      end
      if (reg_wr && reg_sel == SEL_STAT) begin
        if (reg_wdata[SB_DONE]) ev_done <= 1'b0;
        if (reg_wdata[SB_END])  ev_end  <= 1'b0;
        if (reg_wdata[SB_XERR]) ev_xerr <= 1'b0;
        if (reg_wdata[SB_PERR]) ev_perr <= 1'b0;
      end
      if (reg_wr && reg_sel == SEL_DESC && !busy) cur <= reg_wdata[AW-1:0];

      case (state)
        S_IDLE: if (launch) begin
          halted     <= 1'b0;
          abort_pend <= 1'b0;
          state      <= reg_wdata[MB_EXT] ? S_WAIT_PIN : S_ALIGN;
        end
        S_WAIT_PIN: begin
          if (stop_now) begin
            state <= S_IDLE; halted <= 1'b1; abort_pend <= 1'b0;
          end else if (ext_start) state <= S_ALIGN;
        end
        S_ALIGN: begin
          if (cur[ALIGN_LG-1:0] != '0) begin
            ev_perr <= 1'b1; state <= S_IDLE; halted <= 1'b1; abort_pend <= 1'b0;
          end else begin
            widx  <= 2'd0;
            state <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) begin
            ev_xerr <= 1'b1; state <= S_IDLE; halted <= 1'b1; abort_pend <= 1'b0;
          end else begin
            case (widx)
              2'd0:    src     <= mem_rdata[AW-1:0];
              2'd1:    dst     <= mem_rdata[AW-1:0];
              2'd2:    nxt     <= mem_rdata[AW-1:0];
              default: cnt_raw <= mem_rdata;
            endcase
            if (stop_now) begin
              state <= S_IDLE; halted <= 1'b1; abort_pend <= 1'b0;
            end else if (widx == 2'd3) state <= S_CHECK;
            else widx <= widx + 2'd1;
          end
        end
        S_CHECK: begin
          if (cnt_zero) begin
            rem <= '0; ev_perr <= 1'b1; state <= S_IDLE; halted <= 1'b1; abort_pend <= 1'b0;
          end else if (cnt_bad || nxt[ALIGN_LG-1:1] != '0) begin
            ev_perr <= 1'b1; state <= S_IDLE; halted <= 1'b1; abort_pend <= 1'b0;
          end else begin
            rem   <= cnt_raw[CW-1:0];
            state <= S_READ;
          end
        end
        S_READ: if (mem_ack) begin
          if (mem_err) begin
            ev_xerr <= 1'b1; state <= S_IDLE; halted <= 1'b1; abort_pend <= 1'b0;
          end else begin
            dbuf <= mem_rdata;
            src  <= src + AW'(4);
            if (stop_now) begin
              state <= S_IDLE; halted <= 1'b1; abort_pend <= 1'b0;
            end else state <= S_WRITE;
          end
        end
        S_WRITE: if (mem_ack) begin
          if (mem_err) begin
            ev_xerr <= 1'b1; state <= S_IDLE; halted <= 1'b1; abort_pend <= 1'b0;
          end else begin
            dst <= dst + AW'(4);
            rem <= rem - CW'(4);
            if (last_beat) ev_done <= 1'b1;
            if (last_beat && nxt[0]) begin
              ev_end <= 1'b1;
              state  <= S_IDLE;
            end else if (stop_now) begin
              state <= S_IDLE; halted <= 1'b1; abort_pend <= 1'b0;
            end else if (last_beat) begin
              cur   <= {nxt[AW-1:1], 1'b0};
              state <= S_ALIGN;
            end else state <= S_READ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R3
  AST_ALIGNED_MOVE: assert property (@(posedge clk) disable iff (rst)
    (state == S_READ || state == S_WRITE) |-> (cur[ALIGN_LG-1:0] == '0)); // R10
  AST_CNT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (state == S_READ) |-> (rem != '0 && int'(rem) <= MAX_BYTES)); // R11
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (rst)
    halted |-> (state == S_IDLE)); // R8
  AST_END_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $rose(ev_end) |-> (state == S_IDLE && !halted)); // R5
endmodule

// File: tb/dchain_seq_tb.sv
module dchain_seq_tb;
  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ext_start = 1'b0;
  logic        mem_req, mem_we, mem_ack, mem_err, irq;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [0:1023];
  logic        pk_en = 1'b0;
  logic [15:0] pk_a = '0;
  logic [31:0] pk_d = '0;
  logic [15:0] err_addr = 16'hFFFC;
  bit          sb_on = 1'b1;
  logic [47:0] sbq [$];
  int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0, n_wr = 0;

  always #4 clk = ~clk;

  dchain_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ext_start(ext_start), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .irq(irq));

  always @(posedge clk) begin
    if (pk_en) mem[pk_a[11:2]] <= pk_d;
    if (rst) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_err <= (mem_addr == err_addr);
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end else begin
      mem_ack <= 1'b0; mem_err <= 1'b0;
    end
  end

  // Scoreboard monitor: every accepted write is compared with the queue head.
  always @(negedge clk) begin
    if (!rst && mem_req && mem_we && mem_ack && !mem_err) begin
      n_wr++;
      if (sb_on) begin
        mon_chk++;
        if (sbq.size() == 0) begin
          mon_fail++;
          $display("FAIL R3 unexpected write actual=%h/%h expected=none", mem_addr, mem_wdata);
        end else begin
          logic [47:0] e;
          e = sbq.pop_front();
          if ({mem_addr, mem_wdata} !== e) begin
            mon_fail++;
            $display("FAIL R3 write actual=%h/%h expected=%h/%h", mem_addr, mem_wdata, e[47:32], e[31:0]);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + mon_chk + 1, n_fail + mon_fail + 1);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    reg_sel = sel; #1; d = reg_rdata;
  endtask

  task automatic poke(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    pk_en = 1'b1; pk_a = a; pk_d = d;
    @(negedge clk);
    pk_en = 1'b0;
  endtask

  task automatic desc(input logic [15:0] at, input logic [31:0] s, dd, nx, c);
    poke(at, s); poke(at + 16'd4, dd); poke(at + 16'd8, nx); poke(at + 16'd12, c);
  endtask

  task automatic expect_copy(input logic [15:0] s, input logic [15:0] dd, input int c);
    for (int k = 0; k < c / 4; k++)
      sbq.push_back({dd + 16'(4 * k), mem[(s >> 2) + k]});
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    int n = 0;
    do begin
      @(negedge clk); rd(2'd1, st); n++;
    end while (st[4] && n < 3000);
  endtask

  task automatic prep(input logic [15:0] at);
    wr(2'd0, 32'h0); wr(2'd1, 32'hF); wr(2'd2, {16'h0, at});
  endtask

  logic [31:0] v;
  int w0;
  bit any_req;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd(2'd0, v); chk("R1 mode", v, 32'h0);
    rd(2'd1, v); chk("R1 status", v, 32'h0);
    rd(2'd2, v); chk("R1 cur", v, 32'h0);
    rd(2'd3, v); chk("R1 count", v, 32'h0);
    chk("R1 irq/req", {30'd0, irq, mem_req}, 32'h0);

    for (int k = 0; k < 16; k++) poke(16'h200 + 16'(4 * k), 32'hA500_0000 + 32'(k * 32'h1111));

    // single descriptor, end flag set
    desc(16'h100, 32'h200, 32'h300, 32'h001, 32'd16);
    expect_copy(16'h200, 16'h300, 16);
    prep(16'h100);
    wr(2'd0, 32'h9);
    rd(2'd1, v); chk("R2 busy after launch", {31'd0, v[4]}, 32'h1);
    wait_idle();
    chk("R3 queue drained", sbq.size(), 0);
    rd(2'd1, v); chk("R5 status done+end", v, 32'h3);
    @(negedge clk);
    chk("R14 irq on end", {31'd0, irq}, 32'h1);
    wr(2'd1, 32'h2);
    rd(2'd1, v); chk("R13 clear end only", v, 32'h1);
    @(negedge clk);
    chk("R14 irq falls", {31'd0, irq}, 32'h0);
    wr(2'd1, 32'h1);

    // start already set: no relaunch
    wr(2'd0, 32'h9);
    repeat (3) @(negedge clk);
    rd(2'd1, v); chk("R6 no relaunch", v, 32'h0);

    // two-descriptor chain
    desc(16'h100, 32'h200, 32'h400, 32'h140, 32'd8);
    desc(16'h140, 32'h220, 32'h500, 32'h001, 32'd12);
    expect_copy(16'h200, 16'h400, 8);
    expect_copy(16'h220, 16'h500, 12);
    prep(16'h100);
    wr(2'd0, 32'h1);
    begin
      int n = 0;
      logic [31:0] cv, st;
      do begin
        @(negedge clk); rd(2'd2, cv); rd(2'd1, st); n++;
      end while (!(cv == 32'h140 && st[4]) && n < 500);
      chk("R4 cur tracks second descriptor while busy", cv, 32'h140);
    end
    wait_idle();
    chk("R3 chain queue drained", sbq.size(), 0);
    rd(2'd2, v); chk("R4 cur after chain", v, 32'h140);
    rd(2'd1, v); chk("R5 chain end not halted", v, 32'h3);

    // external start
    expect_copy(16'h200, 16'h400, 8);
    expect_copy(16'h220, 16'h500, 12);
    prep(16'h100);
    wr(2'd0, 32'h5);
    any_req = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); if (mem_req) any_req = 1'b1;
    end
    rd(2'd1, v);
    chk("R7 waiting busy, no request", {30'd0, v[4], any_req}, 32'h2);
    @(negedge clk); ext_start = 1'b1;
    @(negedge clk); ext_start = 1'b0;
    wait_idle();
    chk("R7 ran after pin", sbq.size(), 0);
    rd(2'd1, v); chk("R7 end status", v, 32'h3);

    // abort
    sb_on = 1'b0;
    desc(16'h180, 32'h200, 32'h600, 32'h001, 32'd64);
    prep(16'h180);
    w0 = n_wr;
    wr(2'd0, 32'h11);
    repeat (10) @(negedge clk);
    wr(2'd0, 32'h13);
    wait_idle();
    rd(2'd1, v); chk("R8 abort halted", v, 32'h20);
    chk("R8 abort partial", (n_wr - w0 < 16) ? 32'h1 : 32'h0, 32'h1);
    any_req = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); if (mem_req) any_req = 1'b1;
    end
    chk("R8 no request after abort", {31'd0, any_req}, 32'h0);
    chk("R14 no irq on abort", {31'd0, irq}, 32'h0);

    // halt by clearing start and ext enable
    prep(16'h180);
    wr(2'd0, 32'h1);
    repeat (10) @(negedge clk);
    wr(2'd0, 32'h0);
    wait_idle();
    rd(2'd1, v); chk("R9 halt by clear", v, 32'h20);

    // unaligned current address
    prep(16'h104);
    w0 = n_wr;
    wr(2'd0, 32'h11);
    wait_idle();
    rd(2'd1, v); chk("R10 unaligned cur", v, 32'h28);
    chk("R10 no data written", n_wr - w0, 0);
    @(negedge clk);
    chk("R14 irq on error", {31'd0, irq}, 32'h1);
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R13 write zero keeps bits", v, 32'h28);

    // unaligned link
    desc(16'h1C0, 32'h200, 32'h700, 32'h148, 32'd4);
    prep(16'h1C0);
    w0 = n_wr;
    wr(2'd0, 32'h1);
    wait_idle();
    rd(2'd1, v); chk("R10 unaligned link", v, 32'h28);
    chk("R10 link no data", n_wr - w0, 0);

    // zero count
    desc(16'h1E0, 32'h200, 32'h700, 32'h001, 32'd0);
    prep(16'h1E0);
    wr(2'd0, 32'h1);
    wait_idle();
    rd(2'd1, v); chk("R11 zero count", v, 32'h28);
    rd(2'd3, v); chk("R11 count reads zero", v, 32'h0);

    // count above max and unaligned count
    desc(16'h1E0, 32'h200, 32'h700, 32'h001, 32'd1028);
    prep(16'h1E0);
    w0 = n_wr;
    wr(2'd0, 32'h1);
    wait_idle();
    rd(2'd1, v); chk("R11 over max", v, 32'h28);
    desc(16'h1E0, 32'h200, 32'h700, 32'h001, 32'd6);
    prep(16'h1E0);
    wr(2'd0, 32'h1);
    wait_idle();
    rd(2'd1, v); chk("R11 not word multiple", v, 32'h28);
    chk("R11 no data moved", n_wr - w0, 0);

    // transfer error on third source word
    desc(16'h180, 32'h200, 32'h600, 32'h001, 32'd16);
    err_addr = 16'h208;
    prep(16'h180);
    w0 = n_wr;
    wr(2'd0, 32'h1);
    wait_idle();
    rd(2'd1, v); chk("R12 transfer error", v, 32'h24);
    chk("R12 stopped after two words", n_wr - w0, 2);
    any_req = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); if (mem_req) any_req = 1'b1;
    end
    chk("R12 no request after error", {31'd0, any_req}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end
endmodule